// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one burst of a synchronous graphics memory. A mode word loaded through a strobe selects the burst length (1, 2, 4, 8 or a 256-column full page) and the ordering of the beats (sequential or interleave). When a column command starts a burst, the block takes the starting column and drives one column address per clock, flags the final beat, and goes idle. The command decoder, data path and row timing that surround it are not part of this block.

The low bits of the column, inside a window as wide as the burst, follow the selected ordering. The bits above that window keep the starting column's value. A full-page burst runs through all 256 columns and wraps. It continues until a stop request or a new start ends it. Illegal mode words raise an error flag, and the block then falls back to single-beat bursts. The burst settings are captured when a burst starts, so a mode load during a burst affects only the bursts that follow it.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid`, `last_beat` and `mode_err` are 0, `col_out` is 0, and the mode is burst length 1 with sequential ordering.
- R2: `mode_key[2:0]` selects the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a 256-column full page.
- R3: `mode_key[3]` = 0 selects sequential ordering. In that ordering beat k carries the low window bits (start + k) modulo the burst length. For example, length 4 from column 2 gives 2,3,0,1.
- R4: `mode_key[3]` = 1 selects interleave ordering. In that ordering beat k carries the low window bits start XOR k. For example, length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R5: Column bits above the burst window equal the starting column's bits on every beat of the burst.
- R6: A `start` pulse sampled on a clock edge makes `col_valid` 1 after that edge, with `col_out` equal to `start_col` as the first beat.
- R7: In a burst of 1, 2, 4 or 8 beats, `last_beat` is 1 exactly on the final beat. `col_valid` is 0 on the cycle after the final beat unless a new start arrives.
- R8: A full-page burst advances the column by one modulo 256 on every cycle and never raises `last_beat`.
- R9: A `stop` sampled during a full-page burst ends it: the beat shown on that cycle is the last one. A `stop` during any other burst length has no effect.
- R10: A mode word with a reserved length code (100, 101, 110), or with full page combined with interleave, sets `mode_err` to 1 and makes the following bursts one beat long. A legal mode word clears `mode_err`.
- R11: A `start` during a running burst abandons that burst, and the new burst's first column appears on the next cycle.
- R12: A mode load during a burst does not change that burst. The new mode applies from the next start.
- R13: While `col_valid` is 0, `col_out` is 0 and `last_beat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Loads `mode_key` into the mode register |
| mode_key | input | 4 | Bits 2:0 length code, bit 3 ordering |
| start | input | 1 | Starts a burst at `start_col` |
| start_col | input | 8 | Starting column of the burst |
| stop | input | 1 | Ends a full-page burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | The current beat is the final one |
| mode_err | output | 1 | The loaded mode word is illegal |

## Verification
The assertions check the following on every cycle: the first beat follows each start with the starting column, a finite burst keeps running until `last_beat`, the burst ends after `last_beat`, idle outputs are zero, and `mode_err` follows each loaded key. The following can only be shown by the bench's scenarios: the ordering of the beats for each length and type, the fixed upper bits, the 256-column wrap, a stop that ends a full-page burst while a stop in a shorter burst changes nothing, a restart in the middle of a burst, and a mode change that waits for the next start.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8,
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last_beat,
  output logic             mode_err
);

  localparam logic [COL_W-1:0] FULL_MASK = {COL_W{1'b1}};

  logic [2:0]       len_code;
  logic             il_sel;
  logic             cfg_err;
  logic             cfg_full;
  logic [COL_W-1:0] cfg_mask;

  logic             active;
  logic             b_il;
  logic             b_full;
  logic [COL_W-1:0] b_mask;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_code <= 3'b000;
      il_sel   <= 1'b0;
    end else if (mode_load) begin
      len_code <= mode_key[2:0];
      il_sel   <= mode_key[3];
    end
  end

  always_comb begin
    cfg_err  = 1'b0;
    cfg_full = 1'b0;
    cfg_mask = '0;
    case (len_code)
      3'b000: cfg_mask = COL_W'(0);
      3'b001: cfg_mask = COL_W'(1);
      3'b010: cfg_mask = COL_W'(3);
      3'b011: cfg_mask = COL_W'(7);
      3'b111: begin
        if (il_sel) begin
          cfg_err = 1'b1;
        end else begin
          cfg_full = 1'b1;
          cfg_mask = FULL_MASK;
        end
      end
      default: cfg_err = 1'b1;
    endcase
  end

  assign mode_err = cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      b_il   <= 1'b0;
      b_full <= 1'b0;
      b_mask <= '0;
      base   <= '0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      b_il   <= il_sel;
      b_full <= cfg_full;
      b_mask <= cfg_mask;
      base   <= start_col;
      beat   <= '0;
    end else if (active) begin
      if (b_full && stop)
        active <= 1'b0;
      else if (last_beat)
        active <= 1'b0;
      else
        beat <= beat + 1'b1;
    end
  end

  assign low       = b_il ? (base ^ beat) : (base + beat);
  assign col_valid = active;
  assign last_beat = active && !b_full && (beat == b_mask);
  assign col_out   = active ? ((base & ~b_mask) | (low & b_mask)) : '0;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8,
  parameter int KEY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [KEY_W-1:0] mode_key,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last_beat,
  input logic             mode_err
);

  assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  assert_last_is_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);

  assert_keeps_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !last_beat && !start && !stop) |=> col_valid);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_out == '0 && !last_beat));

  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (mode_err == ($past(mode_key[2:0]) inside {3'b100, 3'b101, 3'b110}
                               || ($past(mode_key[2:0]) == 3'b111 && $past(mode_key[3])))));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_key(mode_key),
  .start(start), .start_col(start_col), .stop(stop), .col_out(col_out),
  .col_valid(col_valid), .last_beat(last_beat), .mode_err(mode_err)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [3:0] mode_key = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       stop = 1'b0;
  logic [7:0] col_out;
  logic       col_valid;
  logic       last_beat;
  logic       mode_err;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t expq[$];

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_key(mode_key),
    .start(start), .start_col(start_col), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .last_beat(last_beat), .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] b, input logic [7:0] m,
                                         input logic il, input int k);
    logic [7:0] lo;
    lo = il ? (b ^ 8'(k)) : (b + 8'(k));
    return (b & ~m) | (lo & m);
  endfunction

  always @(negedge clk) begin
    if (rst_n && col_valid) begin
      if (expq.size() == 0) begin
        check("unexpected beat", {24'h0, col_out}, 32'hFFFF_FFFF);
      end else begin
        item_t it;
        it = expq.pop_front();
        check({it.tag, " column"}, {24'h0, col_out}, {24'h0, it.col});
        check({it.tag, " last"}, {31'h0, last_beat}, {31'h0, it.last});
      end
    end
  end

  task automatic push(input logic [7:0] c, input logic l, input string tag);
    item_t it;
    it.col = c; it.last = l; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic push_burst(input logic [7:0] b, input logic [7:0] m, input logic il,
                            input int n, input string tag);
    for (int k = 0; k < n; k++)
      push(exp_col(b, m, il, k), (k == int'(m)), tag);
  endtask

  task automatic set_mode(input logic [3:0] key);
    @(negedge clk); mode_load = 1'b1; mode_key = key;
    @(negedge clk); mode_load = 1'b0;
  endtask

  task automatic pulse_start(input logic [7:0] c);
    @(negedge clk); start = 1'b1; start_col = c;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic expect_idle(input string tag);
    check({tag, " idle"}, {31'h0, col_valid}, 32'h0);
    check({tag, " drained"}, expq.size(), 32'h0);
  endtask

  task automatic run_burst(input logic [7:0] c, input logic [7:0] m, input logic il,
                           input string tag);
    push_burst(c, m, il, int'(m) + 1, tag);
    pulse_start(c);
    repeat (int'(m) + 1) @(negedge clk);
    expect_idle(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check("watchdog", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 valid", {31'h0, col_valid}, 32'h0);
    check("R1 col", {24'h0, col_out}, 32'h0);
    check("R1 last", {31'h0, last_beat}, 32'h0);
    check("R1 err", {31'h0, mode_err}, 32'h0);
    rst_n = 1'b1;
    run_burst(8'h37, 8'h00, 1'b0, "R1 default len1");

    set_mode(4'b0010);
    run_burst(8'h02, 8'h03, 1'b0, "R3 seq len4");
    set_mode(4'b1010);
    run_burst(8'h02, 8'h03, 1'b1, "R4 il len4");
    set_mode(4'b1011);
    run_burst(8'h05, 8'h07, 1'b1, "R4 il len8");
    set_mode(4'b0011);
    run_burst(8'hAE, 8'h07, 1'b0, "R5 upper bits len8");
    set_mode(4'b0001);
    run_burst(8'hFF, 8'h01, 1'b0, "R2 len2");
    set_mode(4'b1000);
    run_burst(8'h5A, 8'h00, 1'b1, "R2 len1");

    // R8 full page wraps, R9 stop ends it
    set_mode(4'b0111);
    check("R10 full seq legal", {31'h0, mode_err}, 32'h0);
    for (int k = 0; k < 260; k++) push(8'(8'hFD + k), 1'b0, "R8 full page");
    pulse_start(8'hFD);
    repeat (259) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    expect_idle("R9 stop full page");

    // R9 stop ignored for len4
    set_mode(4'b0010);
    push_burst(8'h50, 8'h03, 1'b0, 4, "R9 stop ignored");
    pulse_start(8'h50);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (3) @(negedge clk);
    expect_idle("R9 stop ignored");

    // R10 reserved codes
    for (int c = 4; c < 7; c++) begin
      set_mode({1'b0, 3'(c)});
      check("R10 reserved err", {31'h0, mode_err}, 32'h1);
      run_burst(8'h9C, 8'h00, 1'b0, "R10 fallback len1");
    end
    set_mode(4'b1111);
    check("R10 full il err", {31'h0, mode_err}, 32'h1);
    run_burst(8'h41, 8'h00, 1'b0, "R10 full il fallback");
    set_mode(4'b0011);
    check("R10 err cleared", {31'h0, mode_err}, 32'h0);

    // R11 restart mid burst
    push_burst(8'h10, 8'h07, 1'b0, 2, "R11 first");
    push_burst(8'h63, 8'h07, 1'b0, 8, "R11 restart");
    pulse_start(8'h10);
    pulse_start(8'h63);
    repeat (8) @(negedge clk);
    expect_idle("R11 restart");

    // R12 mode load mid burst
    set_mode(4'b0010);
    push_burst(8'h11, 8'h03, 1'b0, 4, "R12 running");
    pulse_start(8'h11);
    set_mode(4'b1011);
    repeat (2) @(negedge clk);
    expect_idle("R12 running");
    run_burst(8'h05, 8'h07, 1'b1, "R12 new mode");

    repeat (3) @(negedge clk);
    check("R13 idle col", {24'h0, col_out}, 32'h0);
    finish_run();
  end
endmodule